// File: doc/BRIEF.md
# Four-Phase Handshake Channel Bridge

This block joins a request/acknowledge handshake channel to a synchronous valid/ready stream, in both directions. The channel carries single-rail data next to one request wire and one acknowledge wire. The sender pushes each transfer by presenting data and then signalling on request. The receive path captures the word on the active request event and offers it as a stream beat. It answers with acknowledge only once the stream has taken that beat. The send path takes one stream beat, drives it onto the channel with a request, and waits for the acknowledge before it takes the next beat.

The parameter `TWO_PHASE` picks the signalling. With `TWO_PHASE = 0` the channel is four-phase: request rising starts a transfer, acknowledge rising completes it, and both wires must fall back to zero before the next transfer. With `TWO_PHASE = 1` every transition of request is a new transfer and every transition of acknowledge completes one, with no return to zero. Request and acknowledge inputs are assumed to be synchronous to `clk_i` already. Each direction keeps at most one transfer in flight.

Top module: `hs_bridge`

## Requirements
- R1: After reset `rx_ack_o`, `rx_valid_o` and `tx_req_o` are 0 and `tx_ready_o` is 1.
- R2: An active request event on `rx_req_i` captures `rx_data_i`; from the next cycle `rx_valid_o` is 1 and `rx_data_o` holds the captured word, unchanged while `rx_ready_i` is 0, even if `rx_data_i` changes.
- R3: `rx_ack_o` changes only in the cycle after a beat with `rx_valid_o` and `rx_ready_i` both 1; it never changes while the beat waits for `rx_ready_i`.
- R4: Four-phase mode: after the beat `rx_ack_o` is 1 and `rx_valid_o` is 0 while `rx_req_i` stays 1; the cycle after `rx_req_i` falls `rx_ack_o` is 0, and no new beat appears until `rx_req_i` rises again.
- R5: A stream beat (`tx_valid_i` and `tx_ready_o` both 1) puts `tx_data_i` on `tx_data_o` and signals request in the next cycle; `tx_ready_o` is 0 from then until the transfer is complete.
- R6: `tx_data_o` stays constant from the request until the acknowledge is seen, whatever `tx_data_i` does.
- R7: Four-phase mode: the cycle after `tx_ack_i` is seen at 1, `tx_req_o` is 0 and `tx_ready_o` stays 0 as long as `tx_ack_i` is 1; `tx_ready_o` returns to 1 the cycle after `tx_ack_i` falls.
- R8: Two-phase mode: each toggle of `rx_req_i` yields one beat, and `rx_ack_o` toggles once per beat taken; each send beat toggles `tx_req_o` once, and a toggle of `tx_ack_i` completes the transfer, with `tx_ready_o` back to 1 the next cycle and `tx_req_o` left at its new level.
- R9: With the send side looped to the receive side, words leave `rx_data_o` in the order they entered `tx_data_i`, none lost and none repeated, under any pattern of stream stalls.
- R10: Two-phase mode: a request held at a steady level after its transfer yields no further beat and no acknowledge change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_req_i | input | 1 | Request from the channel sender |
| rx_data_i | input | DATA_W | Data from the channel sender |
| rx_ack_o | output | 1 | Acknowledge to the channel sender |
| rx_valid_o | output | 1 | Received word valid on the stream |
| rx_ready_i | input | 1 | Stream consumer ready |
| rx_data_o | output | DATA_W | Received word on the stream |
| tx_valid_i | input | 1 | Stream producer valid |
| tx_ready_o | output | 1 | Send side ready for a beat |
| tx_data_i | input | DATA_W | Word from the stream producer |
| tx_req_o | output | 1 | Request to the channel receiver |
| tx_data_o | output | DATA_W | Data to the channel receiver |
| tx_ack_i | input | 1 | Acknowledge from the channel receiver |

## Verification
Directed sequences hold the request high past the acknowledge and change the input data during stalls, which separates a design that captures on the event from one that follows the data wire, and one that waits for the return to zero from one that re-arms early. In two-phase mode the request is left steady after a toggle, which tells a level detector from a transition detector. A looped run with random valid and ready gaps in both modes then compares every received word against a computed sequence, so a lost, repeated or reordered word shows as a mismatch or a count error.

// File: rtl/hsb_pkg.sv
package hsb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_ACK,
    ST_RTZ
  } hs_state_e;
endpackage

// File: rtl/hsb_evt.sv
// Detects an active handshake event on a synchronized line.
// Four-phase: a high level not yet consumed, re-armed when the line is low.
// Two-phase: any level differing from the last consumed level.
module hsb_evt #(
  parameter bit TWO_PHASE = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  input  logic take_i,
  output logic evt_o
);
  logic seen_q;

  generate
    if (TWO_PHASE) begin : g_toggle
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     seen_q <= 1'b0;
        else if (take_i) seen_q <= line_i;
      end
      assign evt_o = line_i ^ seen_q;
    end else begin : g_level
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      seen_q <= 1'b0;
        else if (take_i)  seen_q <= 1'b1;
        else if (!line_i) seen_q <= 1'b0;
      end
      assign evt_o = line_i & ~seen_q;
    end
  endgenerate
endmodule

// File: rtl/hsb_rx.sv
module hsb_rx
  import hsb_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter bit TWO_PHASE = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              ack_o,
  output logic              valid_o,
  input  logic              ready_i,
  output logic [DATA_W-1:0] data_o
);
  hs_state_e         st_q;
  logic              ack_q;
  logic [DATA_W-1:0] data_q;
  logic              evt, take;

  assign take = (st_q == ST_IDLE) && evt;

  hsb_evt #(.TWO_PHASE(TWO_PHASE)) u_req_evt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .line_i(req_i),
    .take_i(take),
    .evt_o (evt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      ack_q  <= 1'b0;
      data_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (take) begin
          data_q <= data_i;
          st_q   <= ST_REQ;
        end
        ST_REQ: if (ready_i) begin
          if (TWO_PHASE) begin
            ack_q <= ~ack_q;
            st_q  <= ST_IDLE;
          end else begin
            ack_q <= 1'b1;
            st_q  <= ST_ACK;
          end
        end
        ST_ACK: if (!req_i) begin
          ack_q <= 1'b0;
          st_q  <= ST_RTZ;
        end
        ST_RTZ: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign ack_o   = ack_q;
  assign valid_o = (st_q == ST_REQ);
  assign data_o  = data_q;

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> valid_o && $stable(data_o));

  generate
    if (TWO_PHASE) begin : g_chk2
      p_ack_after_beat_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(ack_o) |-> $past(valid_o && ready_i));
    end else begin : g_chk4
      p_ack_after_beat_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(ack_o) |-> $past(valid_o && ready_i));
      p_rtz_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(ack_o) |-> $past(!req_i));
      p_one_word_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ack_o |-> !valid_o);
    end
  endgenerate
endmodule

// File: rtl/hsb_tx.sv
module hsb_tx
  import hsb_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter bit TWO_PHASE = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  output logic              ready_o,
  input  logic [DATA_W-1:0] data_i,
  output logic              req_o,
  output logic [DATA_W-1:0] data_o,
  input  logic              ack_i
);
  hs_state_e         st_q;
  logic              req_q;
  logic [DATA_W-1:0] data_q;
  logic              evt, take;

  assign take = (st_q == ST_REQ) && evt;

  hsb_evt #(.TWO_PHASE(TWO_PHASE)) u_ack_evt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .line_i(ack_i),
    .take_i(take),
    .evt_o (evt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      req_q  <= 1'b0;
      data_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (valid_i) begin
          data_q <= data_i;
          req_q  <= TWO_PHASE ? ~req_q : 1'b1;
          st_q   <= ST_REQ;
        end
        ST_REQ: if (take) begin
          if (TWO_PHASE) begin
            st_q <= ST_IDLE;
          end else begin
            req_q <= 1'b0;
            st_q  <= ST_RTZ;
          end
        end
        ST_RTZ: if (!ack_i) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign ready_o = (st_q == ST_IDLE);
  assign req_o   = req_q;
  assign data_o  = data_q;

  p_one_out_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && ready_o |=> !ready_o);
  p_data_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |=> $stable(data_o));

  generate
    if (!TWO_PHASE) begin : g_chk4
      p_req_drop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(req_o) |-> $past(ack_i));
      p_ready_rtz_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ready_o |-> !req_o);
    end else begin : g_chk2
      p_req_toggle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(req_o) |-> $past(valid_i && ready_o));
    end
  endgenerate
endmodule

// File: rtl/hs_bridge.sv
module hs_bridge #(
  parameter int DATA_W    = 8,
  parameter bit TWO_PHASE = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_req_i,
  input  logic [DATA_W-1:0] rx_data_i,
  output logic              rx_ack_o,
  output logic              rx_valid_o,
  input  logic              rx_ready_i,
  output logic [DATA_W-1:0] rx_data_o,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  input  logic [DATA_W-1:0] tx_data_i,
  output logic              tx_req_o,
  output logic [DATA_W-1:0] tx_data_o,
  input  logic              tx_ack_i
);
  hsb_rx #(.DATA_W(DATA_W), .TWO_PHASE(TWO_PHASE)) u_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (rx_req_i),
    .data_i (rx_data_i),
    .ack_o  (rx_ack_o),
    .valid_o(rx_valid_o),
    .ready_i(rx_ready_i),
    .data_o (rx_data_o)
  );

  hsb_tx #(.DATA_W(DATA_W), .TWO_PHASE(TWO_PHASE)) u_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(tx_valid_i),
    .ready_o(tx_ready_o),
    .data_i (tx_data_i),
    .req_o  (tx_req_o),
    .data_o (tx_data_o),
    .ack_i  (tx_ack_i)
  );

  p_reset_r1: assert property (@(posedge clk_i)
    !rst_ni |-> !rx_ack_o && !rx_valid_o && !tx_req_o && tx_ready_o);
endmodule

// File: tb/hs_bridge_tb.sv
module hs_bridge_tb;
  localparam int DW = 8;
  localparam int NW = 300;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic loop = 1'b0;
  logic run = 1'b0;
  always #10 clk = ~clk;

  int total = 0;
  int bad = 0;

  logic          b_rx_req [2];
  logic [DW-1:0] b_rx_data[2];
  logic          b_tx_ack [2];
  logic          rx_ready [2];
  logic          tx_valid [2];
  logic [DW-1:0] tx_data  [2];

  logic          rx_req_w [2];
  logic [DW-1:0] rx_data_w[2];
  logic          tx_ack_w [2];
  logic          rx_ack   [2];
  logic          rx_valid [2];
  logic [DW-1:0] rx_dout  [2];
  logic          tx_ready [2];
  logic          tx_req   [2];
  logic [DW-1:0] tx_dout  [2];

  int sent[2];
  int rcv[2];
  int drv[2];

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] word(input int g, input int i);
    return DW'((i * 29 + g * 101 + 7) ^ (i >> 3));
  endfunction

  for (genvar g = 0; g < 2; g++) begin : gen
    assign rx_req_w[g]  = loop ? tx_req[g]  : b_rx_req[g];
    assign rx_data_w[g] = loop ? tx_dout[g] : b_rx_data[g];
    assign tx_ack_w[g]  = loop ? rx_ack[g]  : b_tx_ack[g];

    hs_bridge #(.DATA_W(DW), .TWO_PHASE(g == 1)) u_dut (
      .clk_i     (clk),
      .rst_ni    (rst_n),
      .rx_req_i  (rx_req_w[g]),
      .rx_data_i (rx_data_w[g]),
      .rx_ack_o  (rx_ack[g]),
      .rx_valid_o(rx_valid[g]),
      .rx_ready_i(rx_ready[g]),
      .rx_data_o (rx_dout[g]),
      .tx_valid_i(tx_valid[g]),
      .tx_ready_o(tx_ready[g]),
      .tx_data_i (tx_data[g]),
      .tx_req_o  (tx_req[g]),
      .tx_data_o (tx_dout[g]),
      .tx_ack_i  (tx_ack_w[g])
    );

    // scoreboard: R9 order, loss, duplication
    always @(posedge clk) if (run) begin
      if (tx_valid[g] && tx_ready[g]) sent[g]++;
      if (rx_valid[g] && rx_ready[g]) begin
        chk($sformatf("R9 mode%0d word%0d", g, rcv[g]), int'(rx_dout[g]), int'(word(g, rcv[g])));
        rcv[g]++;
      end
    end

    always @(negedge clk) if (run) begin
      if (tx_valid[g] && sent[g] > drv[g]) begin
        drv[g] = sent[g];
        tx_valid[g] = 1'b0;
      end
      if (!tx_valid[g] && drv[g] < NW && ($urandom % 4) != 0) begin
        tx_valid[g] = 1'b1;
        tx_data[g]  = word(g, drv[g]);
      end
      rx_ready[g] = ($urandom % 3) != 0;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int g = 0; g < 2; g++) begin
      b_rx_req[g] = 1'b0; b_rx_data[g] = '0; b_tx_ack[g] = 1'b0;
      rx_ready[g] = 1'b0; tx_valid[g] = 1'b0; tx_data[g] = '0;
      sent[g] = 0; rcv[g] = 0; drv[g] = 0;
    end
    step(2);
    for (int g = 0; g < 2; g++) begin
      chk("R1 rx_ack", int'(rx_ack[g]), 0);
      chk("R1 rx_valid", int'(rx_valid[g]), 0);
      chk("R1 tx_req", int'(tx_req[g]), 0);
      chk("R1 tx_ready", int'(tx_ready[g]), 1);
    end
    rst_n = 1'b1;
    step(1);

    // four-phase receive
    b_rx_data[0] = 8'h5A; b_rx_req[0] = 1'b1;
    step(1);
    chk("R2 valid", int'(rx_valid[0]), 1);
    chk("R2 data", int'(rx_dout[0]), 'h5A);
    b_rx_data[0] = 8'h33;
    step(2);
    chk("R2 data held", int'(rx_dout[0]), 'h5A);
    chk("R2 valid held", int'(rx_valid[0]), 1);
    chk("R3 no ack before beat", int'(rx_ack[0]), 0);
    rx_ready[0] = 1'b1;
    step(1);
    chk("R3 ack after beat", int'(rx_ack[0]), 1);
    chk("R4 valid low", int'(rx_valid[0]), 0);
    rx_ready[0] = 1'b0;
    step(2);
    chk("R4 ack held", int'(rx_ack[0]), 1);
    chk("R4 no second beat", int'(rx_valid[0]), 0);
    b_rx_req[0] = 1'b0;
    step(1);
    chk("R4 ack dropped", int'(rx_ack[0]), 0);
    step(2);
    chk("R4 idle after rtz", int'(rx_valid[0]), 0);

    // four-phase send
    tx_data[0] = 8'hC3; tx_valid[0] = 1'b1;
    step(1);
    chk("R5 req", int'(tx_req[0]), 1);
    chk("R5 data", int'(tx_dout[0]), 'hC3);
    chk("R5 ready low", int'(tx_ready[0]), 0);
    tx_data[0] = 8'h11;
    step(2);
    chk("R6 data stable", int'(tx_dout[0]), 'hC3);
    chk("R6 req stable", int'(tx_req[0]), 1);
    tx_valid[0] = 1'b0; b_tx_ack[0] = 1'b1;
    step(1);
    chk("R7 req dropped", int'(tx_req[0]), 0);
    chk("R7 ready low", int'(tx_ready[0]), 0);
    step(1);
    chk("R7 ready waits ack low", int'(tx_ready[0]), 0);
    b_tx_ack[0] = 1'b0;
    step(1);
    chk("R7 ready back", int'(tx_ready[0]), 1);

    // two-phase receive
    b_rx_data[1] = 8'h77; b_rx_req[1] = 1'b1; rx_ready[1] = 1'b1;
    step(1);
    chk("R8 valid", int'(rx_valid[1]), 1);
    chk("R8 data", int'(rx_dout[1]), 'h77);
    step(1);
    chk("R8 ack toggled", int'(rx_ack[1]), 1);
    chk("R8 valid after beat", int'(rx_valid[1]), 0);
    step(2);
    chk("R10 steady req ignored", int'(rx_valid[1]), 0);
    chk("R10 ack steady", int'(rx_ack[1]), 1);
    b_rx_data[1] = 8'h88; b_rx_req[1] = 1'b0;
    step(1);
    chk("R8 second beat", int'(rx_dout[1]), 'h88);
    step(1);
    chk("R8 ack toggled back", int'(rx_ack[1]), 0);
    rx_ready[1] = 1'b0;

    // two-phase send
    tx_data[1] = 8'h9C; tx_valid[1] = 1'b1;
    step(1);
    chk("R8 req toggled", int'(tx_req[1]), 1);
    chk("R8 tx data", int'(tx_dout[1]), 'h9C);
    tx_valid[1] = 1'b0;
    step(1);
    chk("R8 ready low", int'(tx_ready[1]), 0);
    b_tx_ack[1] = 1'b1;
    step(1);
    chk("R8 ready back", int'(tx_ready[1]), 1);
    chk("R8 req kept", int'(tx_req[1]), 1);

    // looped random run, both modes
    rst_n = 1'b0; loop = 1'b1;
    step(2);
    rst_n = 1'b1;
    step(1);
    run = 1'b1;
    while (rcv[0] < NW || rcv[1] < NW) step(1);
    step(40);
    for (int g = 0; g < 2; g++) begin
      chk("R9 received count", rcv[g], NW);
      chk("R9 sent count", sent[g], NW);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule